// File: doc/BRIEF.md
# Two-Stage Integer Pipeline Core

This block is a compact processor for the 32-bit base integer instruction set. It has two overlapping stages. A fetch stage owns the program counter and presents it on an instruction port. An execute stage decodes the word that came back, reads two source registers, runs the ALU, resolves branches and jumps, does any data access and writes the result back, all in one cycle. Because the stages overlap, one instruction completes per clock. The only lost cycle comes from a taken control transfer: the word fetched behind it is dropped.

Instruction and data use separate ports. Instruction memory is read combinationally from the registered fetch address. The data port is combinational from the execute stage, so an asynchronous data memory, or one that runs on the opposite clock edge, returns load data in the same cycle. One halt input freezes the whole core while either memory is not ready. Fences, CSR and system instructions, and unknown opcodes, all retire as no-ops. That lets code compiled for the plain base target run unchanged.

Top module: `twostage_rv_core`

## Requirements
- R1: While reset is high, `imem_addr` equals the reset vector (0 by default) and no data read or write is issued. The cycle right after reset is a bubble, so the first instruction executes after the first clock edge that sees reset low and halt low.
- R2: With no taken transfer and no halt, the fetch address advances by 4 every clock. Consecutive instructions execute in consecutive non-halted cycles.
- R3: A taken branch, JAL or JALR sends fetch to the target. The instruction already fetched behind it is discarded and has no architectural effect. The next instruction executes exactly two non-halted cycles after the transfer.
- R4: The standard base encodings for LUI, AUIPC, the register-register ALU ops (add, sub, sll, slt, sltu, xor, srl, sra, or, and) and the immediate ALU ops produce their architectural results.
- R5: All six conditional branches (eq, ne, lt, ge, ltu, geu) follow their conditions, forward and backward. JAL and JALR write the return address pc+4, and JALR clears bit 0 of its computed target.
- R6: Register x0 always reads as zero. Any write aimed at it is ignored.
- R7: Loads are little-endian and pick lanes by address bits [1:0]. funct3 000 and 001 sign-extend a byte or halfword, 100 and 101 zero-extend them, and 010 returns the whole word.
- R8: A store raises `dmem_wr` with the byte enables set for the addressed lanes only: a byte sets bit addr[1:0], a halfword sets 0011 or 1100, a word sets 1111. `dmem_wdata` carries the byte copied into all four lanes, the halfword copied into both halves, or the word.
- R9: While `halt` is high, the fetch address, the pipeline contents and the registers hold, and `dmem_wr` stays low.
- R10: Fence (opcode 0001111), system and CSR (opcode 1110011) and any unknown opcode change no register and no memory, and fall through to pc+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| halt | input | 1 | Freezes the whole core while high |
| imem_addr | output | XLEN | Registered fetch address |
| imem_data | input | 32 | Instruction word at `imem_addr` |
| dmem_addr | output | XLEN | Effective byte address of the current load or store |
| dmem_rd | output | 1 | A load is executing this cycle |
| dmem_wr | output | 1 | Write strobe for the current store |
| dmem_be | output | XLEN/8 | Byte enables for the store |
| dmem_wdata | output | XLEN | Store data, lane-replicated |
| dmem_rdata | input | XLEN | Word read at `dmem_addr` |

## Verification
The assertions run on every cycle. They check that halt freezes the fetch address and the execute slot, that fetch steps by 4 when no transfer is taken, that a taken transfer always leaves a bubble behind it, and that the reset release starts with an empty slot. They also check that every store has one, two or four lanes enabled, and that byte loads come back with correct sign or zero extension in the upper bits. Only the bench's scenarios can show architectural results. The bench compares every store against an independent instruction-level model, matching address, enables, lane data and the exact non-halted cycle it falls in. Through that comparison it shows that flushed instructions leave no trace, that x0 stays zero, that no-op opcodes are harmless, and that the one-cycle branch penalty holds under an irregular halt pattern.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam logic [6:0] OPC_LUI   = 7'b0110111;
  localparam logic [6:0] OPC_AUIPC = 7'b0010111;
  localparam logic [6:0] OPC_JAL   = 7'b1101111;
  localparam logic [6:0] OPC_JALR  = 7'b1100111;
  localparam logic [6:0] OPC_BR    = 7'b1100011;
  localparam logic [6:0] OPC_LD    = 7'b0000011;
  localparam logic [6:0] OPC_ST    = 7'b0100011;
  localparam logic [6:0] OPC_IMM   = 7'b0010011;
  localparam logic [6:0] OPC_REG   = 7'b0110011;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_SLL, ALU_SLT, ALU_SLTU,
    ALU_XOR, ALU_SRL, ALU_SRA, ALU_OR, ALU_AND
  } alu_op_e;
endpackage

// File: rtl/tsc_regfile.sv
module tsc_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 32
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [$clog2(NREG)-1:0] wa,
  input  logic [XLEN-1:0]         wd,
  input  logic [$clog2(NREG)-1:0] ra1,
  output logic [XLEN-1:0]         rd1,
  input  logic [$clog2(NREG)-1:0] ra2,
  output logic [XLEN-1:0]         rd2
);
  localparam int AW = $clog2(NREG);

  // two asynchronous read ports: maps to distributed (LUT) RAM
  logic [XLEN-1:0] cells [NREG];

  always_ff @(posedge clk) begin
    if (we && wa != AW'(0)) cells[wa] <= wd;
  end

  assign rd1 = (ra1 == AW'(0)) ? '0 : cells[ra1];
  assign rd2 = (ra2 == AW'(0)) ? '0 : cells[ra2];
endmodule

// File: rtl/tsc_alu.sv
module tsc_alu import tsc_pkg::*; #(
  parameter int XLEN = 32
) (
  input  alu_op_e         op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic [2:0]      cmp_f3,
  output logic [XLEN-1:0] y,
  output logic            cmp_true
);
  localparam int SHW = $clog2(XLEN);

  logic [SHW-1:0] sh;
  logic lt_s, lt_u, eq;

  assign sh   = b[SHW-1:0];
  assign lt_s = $signed(a) < $signed(b);
  assign lt_u = a < b;
  assign eq   = (a == b);

  always_comb begin
    case (op)
      ALU_SUB:  y = a - b;
      ALU_SLL:  y = a << sh;
      ALU_SLT:  y = {{(XLEN-1){1'b0}}, lt_s};
      ALU_SLTU: y = {{(XLEN-1){1'b0}}, lt_u};
      ALU_XOR:  y = a ^ b;
      ALU_SRL:  y = a >> sh;
      ALU_SRA:  y = XLEN'($signed(a) >>> sh);
      ALU_OR:   y = a | b;
      ALU_AND:  y = a & b;
      default:  y = a + b;
    endcase
  end

  always_comb begin
    case (cmp_f3)
      3'b000:  cmp_true = eq;
      3'b001:  cmp_true = !eq;
      3'b100:  cmp_true = lt_s;
      3'b101:  cmp_true = !lt_s;
      3'b110:  cmp_true = lt_u;
      3'b111:  cmp_true = !lt_u;
      default: cmp_true = 1'b0;
    endcase
  end
endmodule

// File: rtl/tsc_lsu.sv
module tsc_lsu #(
  parameter int XLEN = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ld_en,
  input  logic                    st_en,
  input  logic [2:0]              f3,
  input  logic [$clog2(XLEN/8)-1:0] ofs,
  input  logic [XLEN-1:0]         st_src,
  input  logic [XLEN-1:0]         rd_word,
  output logic [XLEN/8-1:0]       be,
  output logic [XLEN-1:0]         wdata,
  output logic [XLEN-1:0]         ldata
);
  localparam int NB = XLEN / 8;

  logic [XLEN-1:0] shifted;
  assign shifted = rd_word >> {ofs, 3'b000};

  always_comb begin
    case (f3[1:0])
      2'b00: begin
        be    = NB'(1) << ofs;
        wdata = {NB{st_src[7:0]}};
      end
      2'b01: begin
        be    = NB'(3) << {ofs[$clog2(NB)-1:1], 1'b0};
        wdata = {(NB/2){st_src[15:0]}};
      end
      default: begin
        be    = '1;
        wdata = st_src;
      end
    endcase
  end

  always_comb begin
    case (f3)
      3'b000:  ldata = XLEN'($signed(shifted[7:0]));
      3'b100:  ldata = XLEN'(shifted[7:0]);
      3'b001:  ldata = XLEN'($signed(shifted[15:0]));
      3'b101:  ldata = XLEN'(shifted[15:0]);
      default: ldata = rd_word;
    endcase
  end

  // R8
  st_lanes_chk: assert property (@(posedge clk) disable iff (rst)
    st_en |-> ($countones(be) == 1 || $countones(be) == 2 || $countones(be) == NB));

  // R7
  ld_sext_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_en && f3 == 3'b000) |-> (ldata[XLEN-1:8] == {(XLEN-8){ldata[7]}}));

  // R7
  ld_zext_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_en && f3 == 3'b100) |-> (ldata[XLEN-1:8] == '0));
endmodule

// File: rtl/twostage_rv_core.sv
module twostage_rv_core import tsc_pkg::*; #(
  parameter int          XLEN      = 32,
  parameter int          NREG      = 32,
  parameter logic [31:0] RESET_VEC = 32'h0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              halt,
  output logic [XLEN-1:0]   imem_addr,
  input  logic [31:0]       imem_data,
  output logic [XLEN-1:0]   dmem_addr,
  output logic              dmem_rd,
  output logic              dmem_wr,
  output logic [XLEN/8-1:0] dmem_be,
  output logic [XLEN-1:0]   dmem_wdata,
  input  logic [XLEN-1:0]   dmem_rdata
);
  localparam int NB = XLEN / 8;
  localparam int OW = $clog2(NB);
  localparam int AW = $clog2(NREG);
  localparam logic [31:0] NOP_WORD = 32'h0000_0013;

  // fetch stage / execute slot
  logic [XLEN-1:0] pc_f, pc_x;
  logic [31:0]     ir_x;
  logic            valid_x;

  // decode
  logic [6:0] opc;
  logic [2:0] f3;
  logic [AW-1:0] rd_i, rs1_i, rs2_i;
  logic f7b5;
  logic [XLEN-1:0] imm_i, imm_s, imm_b, imm_u, imm_j;
  logic [XLEN-1:0] rs1_v, rs2_v, alu_b, alu_y, wb_v, ea, ld_v, target;
  logic [NB-1:0] st_be;
  logic [XLEN-1:0] st_wd;
  logic cmp_true, take, is_ld, is_st, wb_en;
  alu_op_e aop;

  assign opc   = ir_x[6:0];
  assign f3    = ir_x[14:12];
  assign rd_i  = AW'(ir_x[11:7]);
  assign rs1_i = AW'(ir_x[19:15]);
  assign rs2_i = AW'(ir_x[24:20]);
  assign f7b5  = ir_x[30];

  assign imm_i = XLEN'($signed(ir_x[31:20]));
  assign imm_s = XLEN'($signed({ir_x[31:25], ir_x[11:7]}));
  assign imm_b = XLEN'($signed({ir_x[31], ir_x[7], ir_x[30:25], ir_x[11:8], 1'b0}));
  assign imm_u = XLEN'($signed({ir_x[31:12], 12'b0}));
  assign imm_j = XLEN'($signed({ir_x[31], ir_x[19:12], ir_x[20], ir_x[30:21], 1'b0}));

  always_comb begin
    case (f3)
      3'b000:  aop = (opc == OPC_REG && f7b5) ? ALU_SUB : ALU_ADD;
      3'b001:  aop = ALU_SLL;
      3'b010:  aop = ALU_SLT;
      3'b011:  aop = ALU_SLTU;
      3'b100:  aop = ALU_XOR;
      3'b101:  aop = f7b5 ? ALU_SRA : ALU_SRL;
      3'b110:  aop = ALU_OR;
      default: aop = ALU_AND;
    endcase
  end

  assign alu_b = (opc == OPC_IMM) ? imm_i : rs2_v;
  assign is_ld = valid_x && opc == OPC_LD;
  assign is_st = valid_x && opc == OPC_ST;
  assign ea    = rs1_v + ((opc == OPC_ST) ? imm_s : imm_i);

  tsc_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk(clk), .we(wb_en), .wa(rd_i), .wd(wb_v),
    .ra1(rs1_i), .rd1(rs1_v), .ra2(rs2_i), .rd2(rs2_v)
  );

  tsc_alu #(.XLEN(XLEN)) u_alu (
    .op(aop), .a(rs1_v), .b(alu_b), .cmp_f3(f3), .y(alu_y), .cmp_true(cmp_true)
  );

  tsc_lsu #(.XLEN(XLEN)) u_lsu (
    .clk(clk), .rst(rst), .ld_en(is_ld), .st_en(is_st), .f3(f3), .ofs(ea[OW-1:0]),
    .st_src(rs2_v), .rd_word(dmem_rdata), .be(st_be), .wdata(st_wd), .ldata(ld_v)
  );

  // control transfer
  always_comb begin
    take   = 1'b0;
    target = pc_x + imm_b;
    if (valid_x) begin
      case (opc)
        OPC_JAL:  begin take = 1'b1; target = pc_x + imm_j; end
        OPC_JALR: begin take = 1'b1; target = (rs1_v + imm_i) & ~XLEN'(1); end
        OPC_BR:   take = cmp_true;
        default:  take = 1'b0;
      endcase
    end
  end

  // writeback
  always_comb begin
    wb_en = valid_x && !halt;
    case (opc)
      OPC_LUI:            wb_v = imm_u;
      OPC_AUIPC:          wb_v = pc_x + imm_u;
      OPC_JAL, OPC_JALR:  wb_v = pc_x + XLEN'(4);
      OPC_LD:             wb_v = ld_v;
      OPC_IMM, OPC_REG:   wb_v = alu_y;
      default: begin      wb_v = alu_y; wb_en = 1'b0; end
    endcase
  end

  // pipeline registers
  always_ff @(posedge clk) begin
    if (rst) begin
      pc_f    <= XLEN'(RESET_VEC);
      pc_x    <= XLEN'(RESET_VEC);
      ir_x    <= NOP_WORD;
      valid_x <= 1'b0;
    end else if (!halt) begin
      pc_f    <= take ? target : pc_f + XLEN'(4);
      pc_x    <= pc_f;
      ir_x    <= imem_data;
      valid_x <= !take;
    end
  end

  assign imem_addr  = pc_f;
  assign dmem_addr  = ea;
  assign dmem_rd    = is_ld && !halt;
  assign dmem_wr    = is_st && !halt;
  assign dmem_be    = dmem_wr ? st_be : '0;
  assign dmem_wdata = st_wd;

  // R9
  halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    halt |=> ($stable(imem_addr) && $stable(valid_x) && $stable(ir_x)));

  // R2
  seq_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    (!halt && !take) |=> (imem_addr == $past(imem_addr) + XLEN'(4)));

  // R3
  flush_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (!halt && take) |=> !valid_x);

  // R1
  reset_bubble_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!valid_x && imem_addr == XLEN'(RESET_VEC)));
endmodule

// File: tb/twostage_rv_core_test.sv
module twostage_rv_core_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        halt = 1'b0;
  logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_rd, dmem_wr;
  logic [3:0]  dmem_be;

  always #2 clk = ~clk;

  twostage_rv_core uut (
    .clk(clk), .rst(rst), .halt(halt),
    .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_rd(dmem_rd), .dmem_wr(dmem_wr),
    .dmem_be(dmem_be), .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata)
  );

  logic [31:0] imem [256];
  logic [31:0] dmem [256];
  logic [31:0] ref_mem [256];
  string       tagmem [256];
  int ip = 0;
  int so = 0;
  int total = 0;
  int bad = 0;
  int n = 0;

  logic [31:0] qa[$], qd[$], qm[$];
  logic [3:0]  qb[$];
  int          qc[$];
  string       qt[$], qtt[$];

  assign imem_data  = imem[imem_addr[9:2]];
  assign dmem_rdata = dmem[dmem_addr[9:2]];

  always @(posedge clk) begin
    if (dmem_wr)
      for (int l = 0; l < 4; l++)
        if (dmem_be[l]) dmem[dmem_addr[9:2]][l*8 +: 8] <= dmem_wdata[l*8 +: 8];
  end

  always @(posedge clk) begin
    if (rst) n <= 0;
    else if (!halt) n <= n + 1;
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // ---------------- encoders ----------------
  function automatic logic [31:0] e_r(input logic [6:0] f7, input logic [2:0] f3,
                                      input int rd, input int rs1, input int rs2);
    return {f7, 5'(rs2), 5'(rs1), f3, 5'(rd), 7'h33};
  endfunction
  function automatic logic [31:0] e_i(input logic [6:0] op, input logic [2:0] f3,
                                      input int rd, input int rs1, input int imm);
    return {12'(imm), 5'(rs1), f3, 5'(rd), op};
  endfunction
  function automatic logic [31:0] e_s(input logic [2:0] f3, input int rs1,
                                      input int rs2, input int imm);
    logic [11:0] m = 12'(imm);
    return {m[11:5], 5'(rs2), 5'(rs1), f3, m[4:0], 7'h23};
  endfunction
  function automatic logic [31:0] e_b(input logic [2:0] f3, input int rs1,
                                      input int rs2, input int off);
    logic [12:0] m = 13'(off);
    return {m[12], m[10:5], 5'(rs2), 5'(rs1), f3, m[4:1], m[11], 7'h63};
  endfunction
  function automatic logic [31:0] e_u(input logic [6:0] op, input int rd, input int imm);
    return {20'(imm), 5'(rd), op};
  endfunction
  function automatic logic [31:0] e_j(input int rd, input int off);
    logic [20:0] m = 21'(off);
    return {m[20], m[10:1], m[11], m[19:12], 5'(rd), 7'h6f};
  endfunction

  task automatic put(input logic [31:0] ins, input string tag);
    imem[ip] = ins;
    tagmem[ip] = tag;
    ip++;
  endtask
  task automatic st_w(input int r, input string tag);
    put(e_s(3'b010, 0, r, so), tag);
    so += 4;
  endtask
  task automatic br_case(input logic [2:0] f3, input int a, input int b);
    put(e_i(7'h13, 0, 10, 0, 0), "R5");
    put(e_b(f3, a, b, 8), "R5");
    put(e_i(7'h13, 0, 10, 0, 1), "R3");
    st_w(10, "R5");
  endtask

  task automatic build_program();
    for (int i = 0; i < 256; i++) begin imem[i] = 32'h0; tagmem[i] = "R10"; end
    // R4 register seeding and ALU
    for (int i = 1; i < 32; i++) put(e_i(7'h13, 0, i, 0, i*37 - 600), "R4");
    put(e_u(7'h37, 5, 20'hABCDE), "R4"); st_w(5, "R4");
    put(e_u(7'h17, 6, 3), "R4");         st_w(6, "R4");
    for (int f = 0; f < 8; f++) begin put(e_r(7'h00, 3'(f), 7, 1, 20), "R4"); st_w(7, "R4"); end
    put(e_r(7'h20, 3'b000, 7, 1, 20), "R4"); st_w(7, "R4");
    put(e_r(7'h20, 3'b101, 7, 1, 3), "R4");  st_w(7, "R4");
    put(e_i(7'h13, 3'b000, 8, 1, -77), "R4"); st_w(8, "R4");
    put(e_i(7'h13, 3'b010, 8, 1, -77), "R4"); st_w(8, "R4");
    put(e_i(7'h13, 3'b011, 8, 1, -77), "R4"); st_w(8, "R4");
    put(e_i(7'h13, 3'b100, 8, 1, -77), "R4"); st_w(8, "R4");
    put(e_i(7'h13, 3'b110, 8, 1, -77), "R4"); st_w(8, "R4");
    put(e_i(7'h13, 3'b111, 8, 1, -77), "R4"); st_w(8, "R4");
    put(e_i(7'h13, 3'b001, 8, 31, 5), "R4"); st_w(8, "R4");
    put(e_i(7'h13, 3'b101, 8, 1, 7), "R4");  st_w(8, "R4");
    put(e_i(7'h13, 3'b101, 8, 1, 32'h407), "R4"); st_w(8, "R4");
    // R6 x0
    put(e_i(7'h13, 0, 0, 0, 123), "R6");
    put(e_r(7'h00, 3'b000, 0, 1, 2), "R6");
    put(e_u(7'h37, 0, 5), "R6");
    st_w(0, "R6");
    put(e_r(7'h00, 3'b000, 9, 0, 1), "R6"); st_w(9, "R6");
    // R5 branches
    br_case(3'b000, 1, 1); br_case(3'b000, 1, 2);
    br_case(3'b001, 1, 2); br_case(3'b001, 1, 1);
    br_case(3'b100, 1, 2); br_case(3'b100, 2, 1);
    br_case(3'b101, 2, 1); br_case(3'b101, 1, 1); br_case(3'b101, 1, 2);
    br_case(3'b110, 20, 1); br_case(3'b110, 1, 20);
    br_case(3'b111, 1, 20); br_case(3'b111, 20, 1);
    put(e_i(7'h13, 0, 11, 0, 3), "R5");
    put(e_i(7'h13, 0, 11, 11, -1), "R5");
    put(e_b(3'b001, 11, 0, -4), "R5");
    st_w(11, "R5");
    put(e_j(12, 8), "R5");
    put(e_i(7'h13, 0, 13, 0, 55), "R3");
    st_w(12, "R5"); st_w(13, "R3");
    put(e_u(7'h17, 13, 0), "R5");
    put(e_i(7'h13, 0, 13, 13, 17), "R5");
    put(e_i(7'h67, 0, 14, 13, 0), "R5");
    put(e_i(7'h13, 0, 15, 0, 77), "R3");
    st_w(14, "R5"); st_w(15, "R3");
    // R7 loads
    begin
      int la[11] = '{800, 801, 803, 803, 800, 800, 802, 802, 804, 807, 806};
      int lf[11] = '{0, 0, 0, 4, 4, 1, 1, 5, 2, 0, 1};
      for (int k = 0; k < 11; k++) begin
        put(e_i(7'h03, 3'(lf[k]), 16, 0, la[k]), "R7"); st_w(16, "R7");
      end
    end
    // R8 stores
    put(e_u(7'h37, 17, 20'h12345), "R8");
    put(e_i(7'h13, 0, 17, 17, 32'h678), "R8");
    for (int k = 0; k < 4; k++) put(e_s(3'b000, 0, 17, 900 + k), "R8");
    put(e_s(3'b001, 0, 17, 904), "R8");
    put(e_s(3'b001, 0, 17, 906), "R8");
    put(e_s(3'b010, 0, 17, 908), "R8");
    put(e_s(3'b000, 0, 1, 913), "R8");
    put(e_i(7'h03, 3'b010, 16, 0, 900), "R8"); st_w(16, "R8");
    put(e_i(7'h03, 3'b010, 16, 0, 904), "R8"); st_w(16, "R8");
    // R10 no-op opcodes
    put(32'h0000000F, "R10");
    put(32'h00000073, "R10");
    put({12'h340, 5'd5, 3'b001, 5'd6, 7'h73}, "R10");
    put({20'h0, 5'd7, 7'h7F}, "R10");
    put({20'hFFFFF, 5'd9, 7'h0B}, "R10");
    st_w(6, "R10"); st_w(7, "R10"); st_w(5, "R10"); st_w(9, "R10");
    // register dump
    for (int i = 1; i < 32; i++) st_w(i, "R4");
    put(e_j(0, 0), "R3");
  endtask

  // ---------------- behavioural reference ----------------
  function automatic logic [31:0] ref_alu(input logic [2:0] f3, input bit sub,
                                          input bit arith, input logic [31:0] x,
                                          input logic [31:0] y);
    case (f3)
      3'b000: return sub ? x - y : x + y;
      3'b001: return x << y[4:0];
      3'b010: return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
      3'b011: return (x < y) ? 32'd1 : 32'd0;
      3'b100: return x ^ y;
      3'b101: return arith ? 32'($signed(x) >>> y[4:0]) : x >> y[4:0];
      3'b110: return x | y;
      default: return x & y;
    endcase
  endfunction

  task automatic ref_run();
    logic [31:0] r [32];
    logic [31:0] pc, ins, a, b, val, nxt, ea, w, s, mask, data;
    logic [3:0]  be;
    logic [2:0]  f3;
    int rd, cyc;
    bit wr, taken, since;
    for (int i = 0; i < 32; i++) r[i] = 0;
    pc = 0; cyc = 1; since = 0;
    for (int step = 0; step < 4000; step++) begin
      ins = imem[pc[9:2]];
      if (ins == 32'h0000006f) break;
      f3 = ins[14:12]; rd = int'(ins[11:7]);
      a = r[ins[19:15]]; b = r[ins[24:20]];
      nxt = pc + 4; wr = 0; val = 0; taken = 0;
      case (ins[6:0])
        7'h37: begin val = {ins[31:12], 12'h0}; wr = 1; end
        7'h17: begin val = pc + {ins[31:12], 12'h0}; wr = 1; end
        7'h6f: begin val = pc + 4; wr = 1; taken = 1;
                 nxt = pc + {{11{ins[31]}}, ins[31], ins[19:12], ins[20], ins[30:21], 1'b0}; end
        7'h67: begin val = pc + 4; wr = 1; taken = 1;
                 nxt = (a + {{20{ins[31]}}, ins[31:20]}) & ~32'd1; end
        7'h63: begin
          case (f3)
            3'b000: taken = (a == b);
            3'b001: taken = (a != b);
            3'b100: taken = ($signed(a) < $signed(b));
            3'b101: taken = ($signed(a) >= $signed(b));
            3'b110: taken = (a < b);
            3'b111: taken = (a >= b);
            default: taken = 0;
          endcase
          if (taken) nxt = pc + {{19{ins[31]}}, ins[31], ins[7], ins[30:25], ins[11:8], 1'b0};
        end
        7'h03: begin
          ea = a + {{20{ins[31]}}, ins[31:20]};
          w = ref_mem[ea[9:2]]; s = w >> (8 * ea[1:0]); wr = 1;
          case (f3)
            3'b000: val = {{24{s[7]}}, s[7:0]};
            3'b100: val = {24'h0, s[7:0]};
            3'b001: val = {{16{s[15]}}, s[15:0]};
            3'b101: val = {16'h0, s[15:0]};
            default: val = w;
          endcase
        end
        7'h23: begin
          ea = a + {{20{ins[31]}}, ins[31:25], ins[11:7]};
          case (f3)
            3'b000: begin be = 4'b0001 << ea[1:0]; mask = 32'hFF << (8*ea[1:0]); data = {4{b[7:0]}}; end
            3'b001: begin be = 4'b0011 << ea[1:0]; mask = 32'hFFFF << (8*ea[1:0]); data = {2{b[15:0]}}; end
            default: begin be = 4'b1111; mask = 32'hFFFFFFFF; data = b; end
          endcase
          qa.push_back(ea); qd.push_back(data); qm.push_back(mask); qb.push_back(be);
          qc.push_back(cyc); qt.push_back(tagmem[pc[9:2]]); qtt.push_back(since ? "R3" : "R2");
          since = 0;
          ref_mem[ea[9:2]] = (ref_mem[ea[9:2]] & ~mask) | (data & mask);
        end
        7'h13: begin val = ref_alu(f3, 0, ins[30], a, {{20{ins[31]}}, ins[31:20]}); wr = 1; end
        7'h33: begin val = ref_alu(f3, ins[30], ins[30], a, b); wr = 1; end
        default: ;
      endcase
      if (wr && rd != 0) r[rd] = val;
      cyc += taken ? 2 : 1;
      if (taken) since = 1;
      pc = nxt;
    end
  endtask

  // ---------------- monitor ----------------
  bit          prev_halt = 0;
  logic [31:0] prev_addr = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_halt) chk(imem_addr == prev_addr, "R9", "fetch address moved during halt", imem_addr, prev_addr);
      if (halt) chk(!dmem_wr, "R9", "store strobe while halted", 32'(dmem_wr), 32'h0);
      if (dmem_wr) begin
        if (qa.size() == 0) begin
          chk(0, "R8", "unexpected store", dmem_addr, 32'h0);
        end else begin
          logic [31:0] ea_e, d_e, m_e; logic [3:0] be_e; int c_e; string t_e, tt_e;
          ea_e = qa.pop_front(); d_e = qd.pop_front(); m_e = qm.pop_front();
          be_e = qb.pop_front(); c_e = qc.pop_front(); t_e = qt.pop_front(); tt_e = qtt.pop_front();
          chk(dmem_addr == ea_e, t_e, "store address", dmem_addr, ea_e);
          chk((dmem_wdata & m_e) == (d_e & m_e), t_e, "store data", dmem_wdata & m_e, d_e & m_e);
          chk(dmem_be == be_e, "R8", "byte enables", 32'(dmem_be), 32'(be_e));
          chk(n == c_e, tt_e, "store cycle", 32'(n), 32'(c_e));
        end
      end
      prev_halt = halt;
      prev_addr = imem_addr;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    for (int i = 0; i < 256; i++) begin dmem[i] = 32'h0; end
    dmem[200] = 32'h8091A2F3;
    dmem[201] = 32'h7F6E5D4C;
    for (int i = 0; i < 256; i++) ref_mem[i] = dmem[i];
    build_program();
    ref_run();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(imem_addr == 32'h0, "R1", "fetch address in reset", imem_addr, 32'h0);
    chk(!dmem_wr && !dmem_rd, "R1", "data access in reset", {30'h0, dmem_wr, dmem_rd}, 32'h0);
    @(posedge clk); #1;
    rst = 1'b0;
    for (int k = 0; k < 1500; k++) begin
      halt = (k == 0) || (k % 7 == 3) || (k >= 60 && k < 64) || (k >= 150 && k < 153);
      @(posedge clk); #1;
    end
    halt = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(qa.size() == 0, "R2", "stores still expected", 32'(qa.size()), 32'h0);
    begin
      int mism = 0;
      for (int i = 0; i < 256; i++) if (dmem[i] !== ref_mem[i]) mism++;
      chk(mism == 0, "R8", "final data memory words differing", 32'(mism), 32'h0);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL R2 watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule